// File: doc/BRIEF.md
# Multi-Bank Configurable Interrupt Controller

This block collects 160 interrupt request lines, grouped in five banks of 32, and turns them into five CPU interrupt outputs, one per bank. Each source carries its own trigger setting built from two per-bit configuration registers: a polarity bit and an edge bit. Together they select rising edge, falling edge, high level or low level. Edge events latch into a status bit that software acknowledges through a write-one-to-clear register. Level sources follow their input. Software can also raise any source through a write-one-to-set register.

Every bank presents a six-word window on a simple synchronous register port. Next to its CPU line, each bank also reports the index of its lowest-numbered pending source and a flag saying whether that index is meaningful. Source n sits in bank n/32 at bit n%32. General-purpose pin inputs usually fill sources 64 to 159, in pin order, across banks 2 to 4.

Top module: `multi_bank_intc`

## Requirements
- R1: The trigger mode of a bit follows (polarity, edge): (1,1) is rising edge, (0,1) is falling edge, (1,0) is high level and (0,0) is low level. An input change of the other direction does not raise an edge-mode bit.
- R2: Bank b occupies byte addresses b*0x18 + offset, with status at 0x00, enable at 0x04, set at 0x08, clear at 0x0C, polarity at 0x10 and edge at 0x14. Source n maps to bank n/32, bit n%32, and a write to one bank leaves every other bank unchanged.
- R3: The pending vector of a bank is status AND enable. Bit b of cpu_irq is 1 exactly when bank b has a pending bit, so a status bit whose enable is 0 raises no interrupt.
- R4: first_idx[5b+4:5b] gives the lowest-numbered pending bit of bank b. first_vld[b] is 1 when any bit is pending and 0 otherwise.
- R5: A detected edge sets an edge-mode status bit, and the bit stays set after the input returns, until it is cleared.
- R6: Writing a 1 to a clear bit zeroes that edge-mode status bit on the write's clock edge. Clear bits written as 0 change nothing.
- R7: A level-mode status bit follows the polarity-corrected input each cycle, and a clear write does not keep it low while the level is active.
- R8: Writing a 1 to a set bit forces that status bit to 1 on the write's clock edge, and the CPU line rises if the bit is enabled.
- R9: Inputs pass through two synchronizing flops. A change at an input reaches status and cpu_irq on the third rising clock edge after it, and not before.
- R10: After reset, enable, polarity, edge and status are 0, and neither cpu_irq nor first_vld is asserted.
- R11: reg_rdata shows the addressed register one cycle after the address is presented. Set and clear addresses read as 0, and status reads return the raw bits whatever the enable setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 160 | Raw interrupt inputs, source n at bit n |
| reg_addr | input | 7 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| cpu_irq | output | 5 | Per-bank CPU interrupt lines, bank b at bit b |
| first_idx | output | 25 | Per-bank lowest pending index, 5 bits per bank |
| first_vld | output | 5 | Per-bank flag that first_idx is meaningful |

## Verification
A source input change is due at status, cpu_irq and first_idx on the third rising edge after it. The bench changes inputs at a falling edge and samples one falling edge after the third rising edge. For R9 it also samples after the second rising edge, to show nothing has arrived early. Register writes take effect on the edge that accepts them, so cpu_irq and first_idx are checked at the falling edge right after each write. Read data is registered and is taken at the falling edge after the address is presented.

// File: rtl/multi_bank_intc.sv
module multi_bank_intc #(
  parameter int NB = 5,
  parameter int BW = 32,
  localparam int IW = $clog2(BW),
  localparam int STRIDE = 24,
  localparam int AW = $clog2(NB * STRIDE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB*BW-1:0] src_i,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [BW-1:0]    reg_wdata,
  output logic [BW-1:0]    reg_rdata,
  output logic [NB-1:0]    cpu_irq,
  output logic [NB*IW-1:0] first_idx,
  output logic [NB-1:0]    first_vld
);
  localparam int OFF_STAT = 0;
  localparam int OFF_EN   = 4;
  localparam int OFF_SET  = 8;
  localparam int OFF_CLR  = 12;
  localparam int OFF_POL  = 16;
  localparam int OFF_EDGE = 20;

  logic [NB*BW-1:0] sync1, sync2, sync3;
  logic [NB*BW-1:0] stat_v, en_v, pol_v, edg_v;
  logic [BW-1:0]    rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BASE = b * STRIDE;
    logic [BW-1:0] stat_r, en_r, pol_r, edg_r;
    logic [BW-1:0] set_w, clr_w, cor, cor_d, det, pend;
    logic          wr_en, wr_pol, wr_edg;

    assign wr_en  = reg_we && (reg_addr == AW'(BASE + OFF_EN));
    assign wr_pol = reg_we && (reg_addr == AW'(BASE + OFF_POL));
    assign wr_edg = reg_we && (reg_addr == AW'(BASE + OFF_EDGE));
    assign set_w  = (reg_we && (reg_addr == AW'(BASE + OFF_SET))) ? reg_wdata : '0;
    assign clr_w  = (reg_we && (reg_addr == AW'(BASE + OFF_CLR))) ? reg_wdata : '0;

    assign cor   = sync2[b*BW +: BW] ^ ~pol_r;
    assign cor_d = sync3[b*BW +: BW] ^ ~pol_r;
    assign det   = edg_r & cor & ~cor_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_r <= '0;
        en_r   <= '0;
        pol_r  <= '0;
        edg_r  <= '0;
      end else begin
        stat_r <= (edg_r & (det | (stat_r & ~clr_w))) | (~edg_r & cor) | set_w;
        if (wr_en)  en_r  <= reg_wdata;
        if (wr_pol) pol_r <= reg_wdata;
        if (wr_edg) edg_r <= reg_wdata;
      end
    end

    assign pend       = stat_r & en_r;
    assign cpu_irq[b] = |pend;

    always_comb begin
      first_idx[b*IW +: IW] = '0;
      first_vld[b]          = 1'b0;
      for (int i = BW - 1; i >= 0; i--) begin
        if (pend[i]) begin
          first_idx[b*IW +: IW] = IW'(i);
          first_vld[b]          = 1'b1;
        end
      end
    end

    assign stat_v[b*BW +: BW] = stat_r;
    assign en_v[b*BW +: BW]   = en_r;
    assign pol_v[b*BW +: BW]  = pol_r;
    assign edg_v[b*BW +: BW]  = edg_r;
  end

  always_comb begin
    rd_n = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == AW'(b * STRIDE + OFF_STAT)) rd_n = stat_v[b*BW +: BW];
      if (reg_addr == AW'(b * STRIDE + OFF_EN))   rd_n = en_v[b*BW +: BW];
      if (reg_addr == AW'(b * STRIDE + OFF_POL))  rd_n = pol_v[b*BW +: BW];
      if (reg_addr == AW'(b * STRIDE + OFF_EDGE)) rd_n = edg_v[b*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_n;
  end
endmodule

// File: rtl/multi_bank_intc_chk.sv
module multi_bank_intc_chk #(
  parameter int NB = 5,
  parameter int BW = 32,
  localparam int IW = $clog2(BW),
  localparam int AW = $clog2(NB * 24)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_we,
  input logic [BW-1:0]    reg_wdata,
  input logic [NB-1:0]    cpu_irq,
  input logic [NB*IW-1:0] first_idx,
  input logic [NB-1:0]    first_vld,
  input logic [NB*BW-1:0] stat_v,
  input logic [NB*BW-1:0] en_v
);
  // R4: valid flag and CPU line agree
  p_vld_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    first_vld == cpu_irq);

  // R10: first cycle out of reset has no interrupt
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_irq == '0 && first_vld == '0));

  // R2: enable state only changes on a write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(en_v));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    logic [BW-1:0] pend;
    logic [IW-1:0] idx;
    assign pend = stat_v[b*BW +: BW] & en_v[b*BW +: BW];
    assign idx  = first_idx[b*IW +: IW];

    // R4: reported index is pending and nothing below it is
    p_idx_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      first_vld[b] |-> (pend[idx] && ((pend & ((BW'(1) << idx) - BW'(1))) == '0)));

    // R8: setting an enabled bit raises the bank line
    p_set_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(b * 24 + 8) && ((reg_wdata & en_v[b*BW +: BW]) != '0))
      |=> cpu_irq[b]);
  end
endmodule

bind multi_bank_intc multi_bank_intc_chk #(.NB(NB), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .cpu_irq(cpu_irq), .first_idx(first_idx),
  .first_vld(first_vld), .stat_v(stat_v), .en_v(en_v)
);

// File: tb/multi_bank_intc_test.sv
`timescale 1ns/1ps
module multi_bank_intc_test;
  localparam int ST = 0, EN = 4, SET = 8, CLR = 12, POL = 16, EDG = 20;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [159:0] src = '0;
  logic [6:0]   addr = '0;
  logic         we = 0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [4:0]   irq;
  logic [24:0]  fidx;
  logic [4:0]   fvld;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  multi_bank_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .cpu_irq(irq),
    .first_idx(fidx), .first_vld(fvld)
  );

  function automatic logic [6:0] ra(int b, int off);
    return 7'(b * 24 + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int b, int off, logic [31:0] d);
    addr = ra(b, off); wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int b, int off, output logic [31:0] d);
    addr = ra(b, off);
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic wait3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 irq", 32'(irq), 0);
    chk("R10 vld", 32'(fvld), 0);
    rd(0, EN, d);  chk("R10 enable", d, 0);
    rd(4, POL, d); chk("R10 polarity", d, 0);
    rd(2, EDG, d); chk("R10 edge", d, 0);
    for (int b = 0; b < 5; b++) wr(b, POL, 32'hFFFF_FFFF);
    wait3();
    rd(3, ST, d);  chk("R10 status after init", d, 0);
  endtask

  task automatic t_level_high();
    wr(0, EN, 32'h20);
    src[5] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 not early", 32'(irq), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 R1 level high irq", 32'(irq), 5'b00001);
    chk("R4 idx bank0", 32'(fidx[4:0]), 5);
    wr(0, CLR, 32'h20);
    @(posedge clk); @(negedge clk);
    chk("R7 clear no lasting effect", 32'(irq), 5'b00001);
    src[5] = 0;
    wait3();
    chk("R7 level released", 32'(irq), 0);
    wr(0, EN, 0);
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    src[35] = 1;
    wait3();
    rd(1, ST, d);
    chk("R11 status ignores enable", d, 32'h8);
    chk("R3 masked no irq", 32'(irq), 0);
    wr(1, POL, ~32'h8);
    wr(1, EN, 32'h8);
    chk("R1 low mode input high idle", 32'(irq), 0);
    src[35] = 0;
    wait3();
    chk("R1 R2 level low irq bank1", 32'(irq), 5'b00010);
    chk("R4 idx bank1", 32'(fidx[9:5]), 3);
    src[35] = 1;
    wait3();
    chk("R7 low level released", 32'(irq), 0);
    wr(1, EN, 0);
    wr(1, POL, 32'hFFFF_FFFF);
  endtask

  task automatic t_rising();
    wr(2, EDG, 32'h1);
    wr(2, EN, 32'h1);
    src[64] = 1;
    wait3();
    chk("R1 R2 rising irq bank2", 32'(irq), 5'b00100);
    chk("R4 idx bank2", 32'(fidx[14:10]), 0);
    src[64] = 0;
    wait3();
    chk("R5 sticky after input drops", 32'(irq), 5'b00100);
    wr(2, CLR, 32'h0);
    chk("R6 zero clear no effect", 32'(irq), 5'b00100);
    wr(2, CLR, 32'h1);
    chk("R6 clear acknowledges", 32'(irq), 0);
    wr(2, EN, 0);
    wr(2, EDG, 0);
  endtask

  task automatic t_falling();
    src[127] = 1;
    wait3();
    wr(3, EDG, 32'h8000_0000);
    wr(3, POL, 32'h7FFF_FFFF);
    wr(3, CLR, 32'h8000_0000);
    wr(3, EN, 32'h8000_0000);
    chk("R1 falling idle", 32'(irq), 0);
    src[127] = 0;
    wait3();
    chk("R1 falling irq bank3", 32'(irq), 5'b01000);
    chk("R4 idx bank3 top bit", 32'(fidx[19:15]), 31);
    wr(3, CLR, 32'h8000_0000);
    src[127] = 1;
    wait3();
    chk("R1 rise ignored in falling mode", 32'(irq), 0);
    wr(3, EN, 0);
    wr(3, EDG, 0);
    wr(3, POL, 32'hFFFF_FFFF);
    src[127] = 0;
    wait3();
  endtask

  task automatic t_soft_set();
    logic [31:0] d;
    wr(4, EDG, 32'h400);
    wr(4, EN, 32'h400);
    wr(4, SET, 32'h400);
    chk("R8 set raises irq", 32'(irq), 5'b10000);
    chk("R8 idx bank4", 32'(fidx[24:20]), 10);
    rd(4, SET, d); chk("R11 set reads zero", d, 0);
    rd(4, CLR, d); chk("R11 clear reads zero", d, 0);
    rd(4, ST, d);  chk("R11 status read", d, 32'h400);
    wr(4, CLR, 32'h400);
    chk("R6 soft clear", 32'(irq), 0);
  endtask

  task automatic t_priority();
    wr(4, EDG, 32'hFFFF_FFFF);
    wr(4, EN, 32'hFFFF_FFFF);
    wr(4, SET, 32'h0010_8080);
    chk("R4 lowest of three", 32'(fidx[24:20]), 7);
    wr(4, CLR, 32'h80);
    chk("R4 next lowest", 32'(fidx[24:20]), 15);
    wr(4, CLR, 32'h8000);
    chk("R4 last one", 32'(fidx[24:20]), 20);
    wr(4, CLR, 32'h0010_0000);
    chk("R4 vld drops", 32'(fvld), 0);
    wr(4, SET, 32'h8000_0001);
    chk("R4 bit0 wins", 32'(fidx[24:20]), 0);
    wr(4, CLR, 32'h1);
    chk("R4 bit31", 32'(fidx[24:20]), 31);
    wr(4, CLR, 32'hFFFF_FFFF);
    chk("R3 all cleared", 32'(irq), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4, EN, 0);
    wr(4, SET, 32'h4);
    chk("R3 disabled no irq", 32'(irq), 0);
    rd(4, ST, d); chk("R3 status held", d, 32'h4);
    wr(4, EN, 32'h4);
    chk("R3 enable raises irq", 32'(irq), 5'b10000);
    wr(4, CLR, 32'h4);
    wr(4, EN, 0);
  endtask

  task automatic t_stride();
    logic [31:0] d;
    wr(0, EN, 32'hA5A5_0001);
    rd(0, EN, d);  chk("R2 bank0 enable", d, 32'hA5A5_0001);
    rd(1, EN, d);  chk("R2 bank1 untouched", d, 0);
    rd(4, EDG, d); chk("R2 bank4 edge", d, 32'hFFFF_FFFF);
    wr(0, EN, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_soft_set();
    t_priority();
    t_mask();
    t_stride();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule